// File: doc/BRIEF.md
# Real-Time Clock Register Access Engine

This block is the byte-level register front end of a real-time clock reached over I2C. A separate I2C target handles the bit-level protocol and hands this block four single-cycle events: a write transaction started, a read transaction started, a byte was received, and a byte was taken by the controller. The block keeps a register pointer and a 16-byte register file.

Registers 0 to 6 hold the time fields in this order: seconds, minutes, hours, weekday, day, month and year. A read transaction first captures the live calendar value into these seven registers and then returns bytes starting at the control register, which is the last register. A byte written to a time register is not stored. It is turned into a single-cycle load toward the calendar counter, or, for the weekday, into a stored weekday offset. All other registers are plain storage.

The live calendar gives hours in 24-hour BCD and the weekday as a binary number from 0 to 6. The block translates hours to and from a 12-hour format when the control register asks for it.

Top module: `rtc_reg_engine`

## Requirements
- R1: The pointer advances by one after every data byte received and after every byte request (`tx_req_i`), wrapping from 15 to 0.
- R2: The first byte received after `wr_start_i` is an address byte. Bits 7:4 load the pointer and bits 3:0 appear on `fmt_o`. No register changes and no load pulse is produced.
- R3: `rd_start_i` sets the pointer to 15, so the first byte returned on `tx_data_o` is register 15.
- R4: `rd_start_i` copies the live time into registers 0 to 6. Byte k of `live_time_i` (bits 8k+7:8k) feeds register k. Seconds, minutes, day, month and year are copied unchanged.
- R5: A byte written while the pointer is 7 to 15 is stored unchanged and read back unchanged. It produces no load pulse.
- R6: A byte written while the pointer is 0, 1, 2, 4, 5 or 6 raises `load_o` for exactly the next cycle. In that cycle `load_field_o` equals the pointer and `load_data_o` is the masked byte: 0x7F for seconds and minutes, 0x3F for hours and day, 0x1F for month, and no mask for year.
- R7: Bit 5 of register 15 set selects 24-hour mode, in which the hour is passed through. When the bit is clear, snapshots convert the live hour h as follows:
  - h = 0 gives 0x12.
  - h from 1 to 11 gives BCD(h).
  - h = 12 gives 0x32.
  - h from 13 to 23 gives 0x20 | BCD(h−12).
  Hour writes in 12-hour mode are converted back to 24-hour BCD before the load.
- R8: A write to pointer 3 produces no load. It sets an offset so that later snapshots return weekday ((w + off) mod 7) + 1, where w is the live weekday (0 to 6) and off = (d − 1 − w_write + 7) mod 7. Here d (1 to 7) is bits 2:0 of the written byte and w_write is the live weekday at the time of the write.
- R9: Reset clears all registers, the pointer, the format code, the weekday offset and the pending address-byte flag, and holds `load_o` low.
- R10: `target_addr_o` drives the parameter `TARGET_ADDR`, 7'h32 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_start_i | input | 1 | Write transaction start, one-cycle pulse |
| rd_start_i | input | 1 | Read transaction start, one-cycle pulse |
| rx_valid_i | input | 1 | Received byte valid, one-cycle pulse |
| rx_data_i | input | 8 | Received byte |
| tx_req_i | input | 1 | Byte taken by controller, advances the pointer |
| tx_data_o | output | 8 | Register at the pointer (combinational) |
| live_time_i | input | 56 | Live calendar, byte k is time field k |
| fmt_o | output | 4 | Latched format code |
| load_o | output | 1 | Time load strobe |
| load_field_o | output | 3 | Time field index for the load |
| load_data_o | output | 8 | Masked, 24-hour BCD load value |
| target_addr_o | output | 7 | 7-bit I2C target address |

## Verification
The storage path is swept with four bit patterns XOR-ed with the register index. This separates a stuck or swapped data bit from a wrong register index, and it also checks the wrap from 15 back to 0 during a read.

Every live hour from 0 to 23 is captured once in each hour mode. This exposes the midnight and noon corner cases that a plain subtraction would get wrong. Every 12-hour code is then written back to confirm the reverse translation.

All 49 pairs of live weekday and written weekday are tried, with the live weekday moved between the write and the read, so that an offset which ignores the live value or fails to wrap modulo 7 shows up. Writes of 0xFF across all seven time fields check each mask. A reset in the middle of the run confirms that the offset and the storage are both cleared.

// File: rtl/rtc_reg_pkg.sv
package rtc_reg_pkg;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_DAY  = 3'd4,
    FLD_MON  = 3'd5,
    FLD_YEAR = 3'd6
  } time_fld_e;

  localparam logic [7:0] HOUR_PM = 8'h20;

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
    logic [3:0] tens;
    logic [3:0] ones;
    tens = 4'(v / 7'd10);
    ones = 4'(v % 7'd10);
    return {tens, ones};
  endfunction

  function automatic logic [2:0] mod7(input logic [7:0] v);
    return 3'(v % 8'd7);
  endfunction

  // 24h BCD -> 12h BCD with PM flag
  function automatic logic [7:0] hour_to_12(input logic [7:0] h24);
    logic [6:0] h;
    h = bcd_to_bin({2'b00, h24[5:0]});
    if (h == 7'd0)       return 8'h12;
    else if (h < 7'd12)  return bin_to_bcd(h);
    else if (h == 7'd12) return HOUR_PM | 8'h12;
    else                 return HOUR_PM | bin_to_bcd(h - 7'd12);
  endfunction

  // 12h BCD with PM flag -> 24h BCD
  function automatic logic [7:0] hour_to_24(input logic [7:0] h12);
    logic [6:0] t;
    t = bcd_to_bin({3'b000, h12[4:0]});
    if (h12[5]) t = t + 7'd12;
    if (t == 7'd12 || t == 7'd24) t = t - 7'd12;
    return bin_to_bcd(t);
  endfunction

endpackage

// File: rtl/rtc_ptr_ctrl.sv
module rtc_ptr_ctrl #(
  parameter int unsigned       PTR_W    = 4,
  parameter int unsigned       FMT_W    = 4,
  parameter logic [PTR_W-1:0]  CTRL_IDX = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_start_i,
  input  logic             rd_start_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             tx_req_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [FMT_W-1:0] fmt_o,
  output logic             data_wr_o
);

  localparam logic [PTR_W-1:0] PTR_ONE = 1;

  logic [PTR_W-1:0] ptr_q;
  logic [FMT_W-1:0] fmt_q;
  logic             addr_pend_q;

  // priority: read start, write start, received byte, byte request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      fmt_q       <= '0;
      addr_pend_q <= 1'b0;
    end else if (rd_start_i) begin
      ptr_q <= CTRL_IDX;
    end else if (wr_start_i) begin
      addr_pend_q <= 1'b1;
    end else if (rx_valid_i) begin
      if (addr_pend_q) begin
        ptr_q       <= rx_data_i[7 -: PTR_W];
        fmt_q       <= rx_data_i[FMT_W-1:0];
        addr_pend_q <= 1'b0;
      end else begin
        ptr_q <= ptr_q + PTR_ONE;
      end
    end else if (tx_req_i) begin
      ptr_q <= ptr_q + PTR_ONE;
    end
  end

  assign data_wr_o = rx_valid_i && !rd_start_i && !wr_start_i && !addr_pend_q;
  assign ptr_o     = ptr_q;
  assign fmt_o     = fmt_q;

  p_rd_ptr_ctrl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_i |=> ptr_q == CTRL_IDX);

  p_req_advance_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_i && !rx_valid_i && !rd_start_i && !wr_start_i)
      |=> ptr_q == $past(ptr_q) + PTR_ONE);

  p_addr_byte_ptr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !data_wr_o && !rd_start_i && !wr_start_i)
      |=> (ptr_q == $past(rx_data_i[7 -: PTR_W])) && !addr_pend_q);

endmodule

// File: rtl/rtc_time_xlate.sv
module rtc_time_xlate import rtc_reg_pkg::*; #(
  parameter int unsigned TIME_NUM = 7,
  localparam int unsigned FLD_W   = $clog2(TIME_NUM)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [FLD_W-1:0]          fld_i,
  input  logic [7:0]                wdata_i,
  input  logic                      hour24_i,
  input  logic [TIME_NUM*8-1:0]     live_time_i,
  output logic [TIME_NUM-1:0][7:0]  snap_o,
  output logic                      load_o,
  output logic [FLD_W-1:0]          load_field_o,
  output logic [7:0]                load_data_o
);

  localparam logic [FLD_W-1:0] WDAY_IDX = FLD_W'(FLD_WDAY);

  logic [2:0]       wd_off_q;
  logic [2:0]       live_wd;
  logic             ld_en;
  logic             wd_wr;
  logic [7:0]       ld_data;
  logic [2:0]       off_next;
  logic             load_q;
  logic [FLD_W-1:0] field_q;
  logic [7:0]       data_q;

  assign live_wd = mod7(live_time_i[int'(FLD_WDAY)*8 +: 8]);

  for (genvar i = 0; i < TIME_NUM; i++) begin : g_snap
    if (i == int'(FLD_HOUR)) begin : g_hour
      assign snap_o[i] = hour24_i ? live_time_i[i*8 +: 8]
                                  : hour_to_12(live_time_i[i*8 +: 8]);
    end else if (i == int'(FLD_WDAY)) begin : g_wday
      assign snap_o[i] = {5'b0, mod7({5'b0, live_wd} + {5'b0, wd_off_q}) + 3'd1};
    end else begin : g_pass
      assign snap_o[i] = live_time_i[i*8 +: 8];
    end
  end

  always_comb begin
    case (fld_i)
      FLD_W'(FLD_SEC),
      FLD_W'(FLD_MIN):  ld_data = wdata_i & 8'h7F;
      FLD_W'(FLD_HOUR): ld_data = hour24_i ? (wdata_i & 8'h3F) : hour_to_24(wdata_i & 8'h3F);
      FLD_W'(FLD_DAY):  ld_data = wdata_i & 8'h3F;
      FLD_W'(FLD_MON):  ld_data = wdata_i & 8'h1F;
      default:          ld_data = wdata_i;
    endcase
  end

  assign wd_wr    = wr_en_i && (fld_i == WDAY_IDX);
  assign ld_en    = wr_en_i && (fld_i != WDAY_IDX);
  // (d - 1 - w + 14) mod 7, kept non-negative
  assign off_next = mod7({5'b0, wdata_i[2:0]} + 8'd13 - {5'b0, live_wd});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_off_q <= '0;
      load_q   <= 1'b0;
      field_q  <= '0;
      data_q   <= '0;
    end else begin
      load_q <= ld_en;
      if (ld_en) begin
        field_q <= fld_i;
        data_q  <= ld_data;
      end
      if (wd_wr) wd_off_q <= off_next;
    end
  end

  assign load_o       = load_q;
  assign load_field_o = field_q;
  assign load_data_o  = data_q;

  p_no_wday_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> load_field_o != WDAY_IDX);

  p_sec_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && load_field_o == FLD_W'(FLD_SEC)) |-> !load_data_o[7]);

  p_wday_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_o[int'(FLD_WDAY)] >= 8'd1 && snap_o[int'(FLD_WDAY)] <= 8'd7);

  p_load_follows_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && fld_i != WDAY_IDX) |=> load_o && load_field_o == $past(fld_i));

endmodule

// File: rtl/rtc_reg_file.sv
module rtc_reg_file #(
  parameter int unsigned REG_NUM    = 16,
  parameter int unsigned TIME_NUM   = 7,
  parameter int unsigned CTRL_IDX   = 15,
  parameter int unsigned HOUR24_BIT = 5,
  localparam int unsigned PTR_W     = $clog2(REG_NUM)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     snap_en_i,
  input  logic [TIME_NUM-1:0][7:0] snap_i,
  input  logic                     wr_en_i,
  input  logic [PTR_W-1:0]         ptr_i,
  input  logic [7:0]               wdata_i,
  output logic [7:0]               rd_data_o,
  output logic                     hour24_o
);

  logic [7:0] regs_q [REG_NUM];

  for (genvar r = 0; r < REG_NUM; r++) begin : g_reg
    if (r < TIME_NUM) begin : g_time
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        regs_q[r] <= '0;
        else if (snap_en_i) regs_q[r] <= snap_i[r];
      end
    end else begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 regs_q[r] <= '0;
        else if (wr_en_i && ptr_i == PTR_W'(r))      regs_q[r] <= wdata_i;
      end
    end
  end

  assign rd_data_o = regs_q[ptr_i];
  assign hour24_o  = regs_q[CTRL_IDX][HOUR24_BIT];

  p_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> regs_q[$past(ptr_i)] == $past(wdata_i));

  p_snap_sec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_en_i |=> regs_q[0] == $past(snap_i[0]));

endmodule

// File: rtl/rtc_reg_engine.sv
module rtc_reg_engine import rtc_reg_pkg::*; #(
  parameter int unsigned REG_NUM     = 16,
  parameter int unsigned TIME_NUM    = 7,
  parameter int unsigned HOUR24_BIT  = 5,
  parameter logic [6:0]  TARGET_ADDR = 7'h32,
  localparam int unsigned PTR_W      = $clog2(REG_NUM),
  localparam int unsigned FMT_W      = 8 - PTR_W,
  localparam int unsigned FLD_W      = $clog2(TIME_NUM),
  localparam int unsigned CTRL_IDX   = REG_NUM - 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_start_i,
  input  logic                  rd_start_i,
  input  logic                  rx_valid_i,
  input  logic [7:0]            rx_data_i,
  input  logic                  tx_req_i,
  output logic [7:0]            tx_data_o,
  input  logic [TIME_NUM*8-1:0] live_time_i,
  output logic [FMT_W-1:0]      fmt_o,
  output logic                  load_o,
  output logic [FLD_W-1:0]      load_field_o,
  output logic [7:0]            load_data_o,
  output logic [6:0]            target_addr_o
);

  logic [PTR_W-1:0]          ptr;
  logic                      data_wr;
  logic                      is_time;
  logic                      hour24;
  logic [TIME_NUM-1:0][7:0]  snap;

  assign is_time = ptr < PTR_W'(TIME_NUM);

  rtc_ptr_ctrl #(
    .PTR_W    (PTR_W),
    .FMT_W    (FMT_W),
    .CTRL_IDX (PTR_W'(CTRL_IDX))
  ) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_start_i (wr_start_i),
    .rd_start_i (rd_start_i),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .tx_req_i   (tx_req_i),
    .ptr_o      (ptr),
    .fmt_o      (fmt_o),
    .data_wr_o  (data_wr)
  );

  rtc_time_xlate #(
    .TIME_NUM (TIME_NUM)
  ) u_xlate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (data_wr && is_time),
    .fld_i        (ptr[FLD_W-1:0]),
    .wdata_i      (rx_data_i),
    .hour24_i     (hour24),
    .live_time_i  (live_time_i),
    .snap_o       (snap),
    .load_o       (load_o),
    .load_field_o (load_field_o),
    .load_data_o  (load_data_o)
  );

  rtc_reg_file #(
    .REG_NUM    (REG_NUM),
    .TIME_NUM   (TIME_NUM),
    .CTRL_IDX   (CTRL_IDX),
    .HOUR24_BIT (HOUR24_BIT)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .snap_en_i (rd_start_i),
    .snap_i    (snap),
    .wr_en_i   (data_wr && !is_time),
    .ptr_i     (ptr),
    .wdata_i   (rx_data_i),
    .rd_data_o (tx_data_o),
    .hour24_o  (hour24)
  );

  assign target_addr_o = TARGET_ADDR;

  p_addr_byte_no_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !data_wr && !rd_start_i && !wr_start_i) |=> !load_o);

  p_store_no_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && !is_time) |=> !load_o);

  p_load_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $past(rx_valid_i));

endmodule

// File: tb/tb_rtc_reg_engine.sv
`timescale 1ns/1ps
module tb_rtc_reg_engine;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_start = 1'b0, rd_start = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [7:0]  tx_data;
  logic [55:0] live = '0;
  logic [3:0]  fmt;
  logic        load;
  logic [2:0]  load_field;
  logic [7:0]  load_data;
  logic [6:0]  taddr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  rtc_reg_engine dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_start_i(wr_start), .rd_start_i(rd_start),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .tx_req_i(tx_req), .tx_data_o(tx_data),
    .live_time_i(live), .fmt_o(fmt), .load_o(load), .load_field_o(load_field),
    .load_data_o(load_data), .target_addr_o(taddr)
  );

  logic       got_load;
  logic [2:0] got_field;
  logic [7:0] got_data;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [7:0] code12(input int h);
    if (h == 0)       return bcd(12);
    else if (h < 12)  return bcd(h);
    else if (h == 12) return 8'h20 | bcd(12);
    else              return 8'h20 | bcd(h - 12);
  endfunction

  task automatic set_live(input logic [7:0] s, mi, h, wd, d, mo, y);
    live = {y, mo, d, wd, h, mi, s};
  endtask

  task automatic pulse_wr;
    @(negedge clk); wr_start = 1'b1;
    @(negedge clk); wr_start = 1'b0;
  endtask

  task automatic pulse_rd;
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
    got_load = load; got_field = load_field; got_data = load_data;
  endtask

  task automatic rd_byte(output logic [7:0] v);
    @(negedge clk); v = tx_data; tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h5A; pats[3] = 8'hA5;

    do_reset;
    // R9 / R10 reset state
    chk("R9 reg0 after reset", tx_data, 8'h00);
    chk("R9 fmt after reset", {4'b0, fmt}, 8'h00);
    chk("R9 load after reset", {7'b0, load}, 8'h00);
    chk("R10 target address", {1'b0, taddr}, 8'h32);
    pulse_rd;
    for (int k = 0; k < 16; k++) begin
      rd_byte(v);
      if (k >= 8) chk("R9 storage cleared", v, 8'h00);
    end

    // R1 R2 R3 R4 R5 storage sweep
    set_live(8'h34, 8'h56, 8'h17, 8'd2, 8'h28, 8'h11, 8'h25);
    foreach (pats[p]) begin
      pulse_wr;
      send(8'h7A);
      chk("R2 fmt code", {4'b0, fmt}, 8'h0A);
      chk("R2 addr byte no load", {7'b0, got_load}, 8'h00);
      for (int k = 7; k < 16; k++) begin
        send(pats[p] ^ 8'(k * 17));
        chk("R5 store no load", {7'b0, got_load}, 8'h00);
      end
      pulse_rd;
      for (int k = 0; k < 16; k++) begin
        int idx;
        logic [7:0] e;
        idx = (15 + k) % 16;
        rd_byte(v);
        case (idx)
          0: e = 8'h34; 1: e = 8'h56;
          2: e = ((pats[p] ^ 8'hFF) & 8'h20) != 0 ? 8'h17 : code12(17);
          3: e = 8'd3; 4: e = 8'h28; 5: e = 8'h11; 6: e = 8'h25;
          default: e = pats[p] ^ 8'(idx * 17);
        endcase
        if (idx == 15)     chk("R3 first read is reg15", v, e);
        else if (idx < 7)  chk("R4 snapshot field", v, e);
        else               chk("R5 R1 readback", v, e);
      end
    end

    // R7 hour snapshot sweep in both modes
    for (int m = 0; m < 2; m++) begin
      pulse_wr; send(8'hF0); send(m == 1 ? 8'h20 : 8'h00);
      for (int h = 0; h < 24; h++) begin
        set_live(8'h00, 8'h00, bcd(h), 8'd0, 8'h01, 8'h01, 8'h00);
        pulse_rd;
        rd_byte(v); rd_byte(v); rd_byte(v); rd_byte(v);
        chk("R7 hour snapshot", v, m == 1 ? bcd(h) : code12(h));
      end
    end

    // R7 hour write translation
    for (int m = 0; m < 2; m++) begin
      pulse_wr; send(8'hF0); send(m == 1 ? 8'h20 : 8'h00);
      for (int h = 0; h < 24; h++) begin
        pulse_wr; send(8'h20);
        send(m == 1 ? (bcd(h) | 8'hC0) : code12(h));
        chk("R7 hour load strobe", {7'b0, got_load}, 8'h01);
        chk("R7 hour load data", got_data, bcd(h));
      end
    end

    // R6 masks across all time fields, R8 weekday no load
    pulse_wr; send(8'hF0); send(8'h20);
    pulse_wr; send(8'h05);
    chk("R2 fmt code 5", {4'b0, fmt}, 8'h05);
    for (int k = 0; k < 7; k++) begin
      logic [7:0] e;
      send(8'hFF);
      case (k)
        0, 1: e = 8'h7F; 2, 4: e = 8'h3F; 5: e = 8'h1F; default: e = 8'hFF;
      endcase
      if (k == 3) chk("R8 weekday write no load", {7'b0, got_load}, 8'h00);
      else begin
        chk("R6 load strobe", {7'b0, got_load}, 8'h01);
        chk("R6 load field", {5'b0, got_field}, 8'(k));
        chk("R6 load data mask", got_data, e);
      end
    end
    @(negedge clk);
    chk("R6 load single cycle", {7'b0, load}, 8'h00);

    // R1 wrap 15 -> 0 on writes
    pulse_wr; send(8'hF3);
    chk("R2 fmt code 3", {4'b0, fmt}, 8'h03);
    send(8'h20);
    send(8'h45);
    chk("R1 wrap write to sec", {5'b0, got_field}, 8'h00);
    chk("R1 wrap load data", got_data, 8'h45);

    // R8 weekday offset sweep
    for (int w = 0; w < 7; w++) begin
      for (int d = 1; d <= 7; d++) begin
        int off, w2;
        set_live(8'h00, 8'h00, 8'h00, 8'(w), 8'h01, 8'h01, 8'h00);
        pulse_wr; send(8'h30); send(8'(d));
        off = (d - 1 - w + 7) % 7;
        w2  = (w + 3) % 7;
        set_live(8'h00, 8'h00, 8'h00, 8'(w2), 8'h01, 8'h01, 8'h00);
        pulse_rd;
        rd_byte(v); rd_byte(v); rd_byte(v); rd_byte(v); rd_byte(v);
        chk("R8 weekday snapshot", v, 8'((w2 + off) % 7 + 1));
      end
    end

    // R9 reset in the middle of a run
    do_reset;
    chk("R9 fmt cleared", {4'b0, fmt}, 8'h00);
    set_live(8'h00, 8'h00, 8'h00, 8'd4, 8'h01, 8'h01, 8'h00);
    pulse_rd;
    for (int k = 0; k < 16; k++) begin
      int idx;
      idx = (15 + k) % 16;
      rd_byte(v);
      if (idx == 3)       chk("R9 weekday offset cleared", v, 8'd5);
      else if (idx >= 7)  chk("R9 registers cleared", v, 8'h00);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule